// File: doc/BRIEF.md
# Frame-Gated Serial Transmit Channel

This block is one transmit lane of a multi-lane serial audio port. The CPU writes a word into a holding register. On a frame boundary the word is moved into a shift register, and the shift register sends it out MSB first, one bit per bit clock. The lane drives its pin only while a word is being shifted. At all other times the pin is released to high impedance.

The lane's enable is one bit of a shared transmit control word; the parameter `LANE` picks which bit. Setting the enable takes effect only at a frame sync. Clearing it lets the word in flight finish before the lane goes quiet. In network mode, a brief clear-and-set of the enable during a word still stops the lane at the end of that word, and the lane waits for the next frame sync.

The lane reports an empty flag for the holding register and an underrun flag. In the shared-pin variant, the pin is also a receiver input, and the block drives the pin's direction from the two enables.

Top module: `ser_tx_channel`

## Requirements
- R1: After reset the lane is idle: `sd_oe_o`=0, `pin_rx_sel_o`=0, `cfg_err_o`=0, `urun_o`=0 and `tde_o`=1 (holding register empty).
- R2: Only bit `LANE` of `tcw_i` enables this lane. Every other bit of `tcw_i` has no effect on the pin or on `tde_o`.
- R3: An idle lane starts only on a clock edge where `fs_i`=1 and the enable is set. Bit `WORD_W-1-k` of the loaded word is on `sd_o` with `sd_oe_o`=1 during the k-th cycle after that edge (k = 0 .. `WORD_W-1`).
- R4: Clearing the enable during a word does not cut the word short. All `WORD_W` bits are still sent, and `sd_oe_o` falls in the cycle after the last bit.
- R5: While the lane is idle, `sd_oe_o`=0. A word written while the lane is disabled stays in the holding register: `tde_o` stays 0 even across frame syncs.
- R6: With `net_mode_i`=1, clearing and then setting the enable again within a word stops the lane after that word. `sd_oe_o` stays 0 until the next `fs_i`, and the following word is sent from that frame sync.
- R7: With `net_mode_i`=0, clearing and then setting the enable again before the word ends does not stop the lane. The next word follows with no gap cycle.
- R8: `tde_o` goes to 1 on the edge that moves the holding register into the shift register. A CPU write (`wr_en_i`=1) clears it on the next edge.
- R9: A transfer that happens while `tde_o`=1 sends the previous word again and sets `urun_o`. A CPU write clears `urun_o`.
- R10: With `SHARED_PIN`=1, `pin_rx_sel_o`=1 exactly when the receive enable is set, the transmit enable is clear and no word is in flight. When both enables are clear, `pin_rx_sel_o`=0 and `sd_oe_o`=0.
- R11: With `SHARED_PIN`=1 and both enables set, `cfg_err_o`=1, `sd_oe_o`=0 and `pin_rx_sel_o`=0, and no word is started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fs_i | input | 1 | Frame sync pulse, one bit clock wide |
| net_mode_i | input | 1 | 1 = network mode, 0 = normal mode |
| tcw_i | input | NUM_TX | Transmit control word; bit `LANE` is this lane's enable |
| rx_pair_en_i | input | 1 | Receive enable of the receiver that shares the pin |
| wr_en_i | input | 1 | CPU write strobe for the holding register |
| wr_data_i | input | WORD_W | CPU write data |
| sd_o | output | 1 | Serial data out |
| sd_oe_o | output | 1 | Output enable for the serial pin (0 = high impedance) |
| pin_rx_sel_o | output | 1 | Shared pin set as a receiver input |
| tde_o | output | 1 | Holding register empty |
| urun_o | output | 1 | Underrun: a stale word was sent again |
| cfg_err_o | output | 1 | Transmit and receive enables both set on the shared pin |

## Verification
The bench builds the block with its defaults: `WORD_W`=24, `NUM_TX`=6, `LANE`=2 and `SHARED_PIN`=1. Because `LANE` sits in the middle of the control word, the bench can set the neighbouring bits on both sides of it to show they have no effect. With `SHARED_PIN`=1 the direction logic and the conflict logic of the shared pin are present, so the bench can exercise them. A 24-bit word is short enough that the bench can check back-to-back words, a mid-word disable and a network-mode gap at bit level, with every shifted bit compared.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef enum logic {
    TX_IDLE  = 1'b0,
    TX_SHIFT = 1'b1
  } tx_state_e;
endpackage

// File: rtl/ser_tx_hold.sv
module ser_tx_hold #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              load_i,
  output logic [WORD_W-1:0] data_o,
  output logic              tde_o,
  output logic              urun_o
);
  logic [WORD_W-1:0] data_q, data_d;
  logic              tde_q, tde_d, urun_q, urun_d;

  always_comb begin
    data_d = data_q;
    tde_d  = tde_q;
    urun_d = urun_q;
    if (wr_i) begin
      data_d = wdata_i;
      tde_d  = 1'b0;
      urun_d = 1'b0;
    end else if (load_i) begin
      tde_d = 1'b1;
      if (tde_q) urun_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      tde_q  <= 1'b1;
      urun_q <= 1'b0;
    end else begin
      data_q <= data_d;
      tde_q  <= tde_d;
      urun_q <= urun_d;
    end
  end

  assign data_o = data_q;
  assign tde_o  = tde_q;
  assign urun_o = urun_q;

  // R8: a write empties nothing; it fills the register
  p_wr_clears_tde_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> !tde_o);
  // R8: a transfer without a write leaves the register empty
  p_load_sets_tde_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !wr_i) |=> tde_o);
  // R9: a transfer of a stale word raises the underrun flag
  p_stale_sets_urun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && tde_o && !wr_i) |=> urun_o);
endmodule

// File: rtl/ser_tx_shifter.sv
module ser_tx_shifter #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              busy_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              msb_o,
  output logic              word_end_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (load_i) begin
      sr_d  = data_i;
      cnt_d = LAST_CNT;
    end else if (busy_i) begin
      sr_d = {sr_q[WORD_W-2:0], 1'b0};
      if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign msb_o      = sr_q[WORD_W-1];
  assign word_end_o = busy_i && (cnt_q == '0);

  // R4: a word in flight is never cut short
  p_full_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !word_end_o) |=> busy_i);
endmodule

// File: rtl/ser_tx_frame_ctl.sv
module ser_tx_frame_ctl
  import ser_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fs_i,
  input  logic net_mode_i,
  input  logic en_i,
  input  logic word_end_i,
  output logic load_o,
  output logic busy_o
);
  tx_state_e st_q, st_d;
  logic      off_q, off_d;

  always_comb begin
    st_d   = st_q;
    off_d  = off_q;
    load_o = 1'b0;
    if (st_q == TX_IDLE) load_o = fs_i && en_i;
    else if (word_end_i) load_o = en_i && (fs_i || !(net_mode_i && off_q));
    if (load_o) begin
      st_d  = TX_SHIFT;
      off_d = 1'b0;
    end else begin
      if ((st_q == TX_SHIFT) && word_end_i) st_d = TX_IDLE;
      if ((st_q == TX_SHIFT) && !en_i) off_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TX_IDLE;
      off_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      off_q <= off_d;
    end
  end

  assign busy_o = (st_q == TX_SHIFT);

  // R3: an idle lane wakes only on a frame sync
  p_start_on_fs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(fs_i));
  // R6: after an off pulse in network mode the lane waits for a frame
  p_net_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_end_i && net_mode_i && off_q && !fs_i) |=> !busy_o);
endmodule

// File: rtl/ser_tx_channel.sv
module ser_tx_channel #(
  parameter int WORD_W     = 24,
  parameter int NUM_TX     = 6,
  parameter int LANE       = 2,
  parameter bit SHARED_PIN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_i,
  input  logic              net_mode_i,
  input  logic [NUM_TX-1:0] tcw_i,
  input  logic              rx_pair_en_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              sd_o,
  output logic              sd_oe_o,
  output logic              pin_rx_sel_o,
  output logic              tde_o,
  output logic              urun_o,
  output logic              cfg_err_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              tx_en, en_eff, conflict;
  logic              load, busy, word_end;
  logic [WORD_W-1:0] hold_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign tx_en = tcw_i[LANE];

  generate
    if (SHARED_PIN) begin : g_shared
      assign conflict     = tx_en && rx_pair_en_i;
      assign pin_rx_sel_o = rx_pair_en_i && !tx_en && !busy;
    end else begin : g_solo
      assign conflict     = 1'b0;
      assign pin_rx_sel_o = 1'b0;
    end
  endgenerate

  assign en_eff    = tx_en && !conflict;
  assign cfg_err_o = conflict;

  ser_tx_hold #(.WORD_W(WORD_W)) u_hold (
    .clk(clk), .rst_n(rst_int_n), .wr_i(wr_en_i), .wdata_i(wr_data_i),
    .load_i(load), .data_o(hold_data), .tde_o(tde_o), .urun_o(urun_o)
  );

  ser_tx_frame_ctl u_ctl (
    .clk(clk), .rst_n(rst_int_n), .fs_i(fs_i), .net_mode_i(net_mode_i),
    .en_i(en_eff), .word_end_i(word_end), .load_o(load), .busy_o(busy)
  );

  ser_tx_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_int_n), .load_i(load), .busy_i(busy),
    .data_i(hold_data), .msb_o(sd_o), .word_end_o(word_end)
  );

  assign sd_oe_o = busy && !conflict;

  // R11: contention never reaches the pin
  p_conflict_quiet_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    cfg_err_o |-> (!sd_oe_o && !pin_rx_sel_o));
  // R10: receiver direction and transmit drive are exclusive
  p_rx_no_drive_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    pin_rx_sel_o |-> !sd_oe_o);
endmodule

// File: tb/ser_tx_channel_test.sv
module ser_tx_channel_test;
  localparam int W    = 24;
  localparam int NTX  = 6;
  localparam int LANE = 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           fs, net_mode, rx_en, wr_en;
  logic [NTX-1:0] tcw;
  logic [W-1:0]   wr_data;
  logic           sd, sd_oe, rx_sel, tde, urun, cfg_err;
  int             n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  ser_tx_channel #(.WORD_W(W), .NUM_TX(NTX), .LANE(LANE), .SHARED_PIN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .fs_i(fs), .net_mode_i(net_mode), .tcw_i(tcw),
    .rx_pair_en_i(rx_en), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .sd_o(sd), .sd_oe_o(sd_oe), .pin_rx_sel_o(rx_sel), .tde_o(tde),
    .urun_o(urun), .cfg_err_o(cfg_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [W-1:0] v);
    wr_data = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_fs();
    fs = 1'b1;
    @(negedge clk);
    fs = 1'b0;
  endtask

  // reads one word from the current negedge on; optional mid-word stimuli
  task automatic capture(output logic [W-1:0] w, output bit oe_ok,
                         input int off_at, input int on_at,
                         input int wr_at, input logic [W-1:0] wv);
    w = '0; oe_ok = 1'b1;
    for (int i = 0; i < W; i++) begin
      w = {w[W-2:0], sd};
      if (!sd_oe) oe_ok = 1'b0;
      wr_en = (i == wr_at);
      if (i == wr_at) wr_data = wv;
      if (i == off_at) tcw[LANE] = 1'b0;
      if (i == on_at)  tcw[LANE] = 1'b1;
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic quiet_for(input int n, input string req);
    bit ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (sd_oe) ok = 1'b0;
      @(negedge clk);
    end
    check(req, {31'b0, ok}, 32'd1);
  endtask

  task automatic t_reset();
    check("R1 oe", {31'b0, sd_oe}, 0);
    check("R1 rx_sel", {31'b0, rx_sel}, 0);
    check("R1 cfg_err", {31'b0, cfg_err}, 0);
    check("R1 urun", {31'b0, urun}, 0);
    check("R1 tde", {31'b0, tde}, 1);
  endtask

  task automatic t_other_bits();
    tcw = ~(NTX'(1) << LANE);
    cpu_write(24'h5A5A5A);
    pulse_fs();
    quiet_for(30, "R2 neighbour bits do not enable");
    check("R5 R2 data held while disabled", {31'b0, tde}, 0);
    tcw = '0;
  endtask

  task automatic t_basic();
    logic [W-1:0] w; bit ok;
    tcw[LANE] = 1'b1;
    quiet_for(10, "R3 no start without fs");
    pulse_fs();
    check("R8 tde set on transfer", {31'b0, tde}, 1);
    capture(w, ok, -1, -1, 4, 24'h3C0FF1);
    check("R3 first word bits", {8'b0, w}, {8'b0, 24'h5A5A5A});
    check("R3 oe during word", {31'b0, ok}, 1);
    capture(w, ok, 3, -1, -1, '0);
    check("R4 word finishes after disable", {8'b0, w}, {8'b0, 24'h3C0FF1});
    check("R4 oe held full word", {31'b0, ok}, 1);
    check("R4 oe falls after last bit", {31'b0, sd_oe}, 0);
    cpu_write(24'h123456);
    pulse_fs();
    quiet_for(30, "R5 idle lane stays tri-stated");
    check("R5 no transfer while disabled", {31'b0, tde}, 0);
  endtask

  task automatic t_net_toggle();
    logic [W-1:0] w; bit ok;
    net_mode = 1'b1;
    tcw[LANE] = 1'b1;
    pulse_fs();
    capture(w, ok, 3, 6, 10, 24'hABCDEF);
    check("R6 current word sent", {8'b0, w}, {8'b0, 24'h123456});
    quiet_for(12, "R6 blank until next frame");
    pulse_fs();
    capture(w, ok, -1, -1, -1, '0);
    check("R6 resumes at frame sync", {8'b0, w}, {8'b0, 24'hABCDEF});
    check("R6 oe in resumed word", {31'b0, ok}, 1);
    capture(w, ok, 0, -1, -1, '0);
    net_mode = 1'b0;
    quiet_for(4, "R4 lane stops after disable");
  endtask

  task automatic t_norm_toggle();
    logic [W-1:0] w; bit ok;
    cpu_write(24'h0F0F0F);
    tcw[LANE] = 1'b1;
    pulse_fs();
    capture(w, ok, 3, 6, 10, 24'hF00D42);
    check("R7 first word", {8'b0, w}, {8'b0, 24'h0F0F0F});
    check("R7 continues with no gap", {31'b0, sd_oe}, 1);
    capture(w, ok, 0, -1, -1, '0);
    check("R7 next word back to back", {8'b0, w}, {8'b0, 24'hF00D42});
    check("R7 oe over next word", {31'b0, ok}, 1);
    quiet_for(4, "R4 stop after normal word");
  endtask

  task automatic t_underrun();
    logic [W-1:0] w; bit ok;
    cpu_write(24'h81C3E7);
    check("R9 urun clear before", {31'b0, urun}, 0);
    tcw[LANE] = 1'b1;
    pulse_fs();
    capture(w, ok, -1, -1, -1, '0);
    check("R9 underrun raised", {31'b0, urun}, 1);
    capture(w, ok, 0, -1, -1, '0);
    check("R9 stale word repeated", {8'b0, w}, {8'b0, 24'h81C3E7});
    cpu_write(24'h000001);
    check("R9 write clears underrun", {31'b0, urun}, 0);
    check("R8 write clears tde", {31'b0, tde}, 0);
  endtask

  task automatic t_shared();
    tcw = '0; rx_en = 1'b1;
    @(negedge clk);
    check("R10 receiver selected", {31'b0, rx_sel}, 1);
    check("R10 no drive in rx", {31'b0, sd_oe}, 0);
    rx_en = 1'b0;
    @(negedge clk);
    check("R10 both clear: rx_sel", {31'b0, rx_sel}, 0);
    check("R10 both clear: oe", {31'b0, sd_oe}, 0);
    rx_en = 1'b1; tcw[LANE] = 1'b1;
    @(negedge clk);
    check("R11 conflict flagged", {31'b0, cfg_err}, 1);
    check("R11 rx_sel off", {31'b0, rx_sel}, 0);
    pulse_fs();
    quiet_for(30, "R11 no drive on conflict");
    check("R11 no transfer on conflict", {31'b0, tde}, 0);
    rx_en = 1'b0; tcw = '0;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fs = 1'b0; net_mode = 1'b0; rx_en = 1'b0;
    wr_en = 1'b0; wr_data = '0; tcw = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_other_bits();
    t_basic();
    t_net_toggle();
    t_norm_toggle();
    t_underrun();
    t_shared();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule